// File: doc/BRIEF.md
# Command and Response Byte Engine

This block is the byte-wide command and response path of a security module's host interface, seen from the locality that currently owns it. A host reaches it through a simple register bus with two registers: a status register, whose next two bytes also give a burst count, and a data port. The host first writes the command-ready bit to claim a clean buffer. It then writes the command one byte at a time through the data port and sets the go bit. It waits for the data-available flag and reads the response back through the same data port.

The block parses the total command length from the header as it arrives. It uses that length to drive the expect flag and the burst count, and it drops anything written past the end of the command. Command meaning is left to an executor, which sits outside the block. While the block is executing, the executor reads the command out of the shared byte buffer, writes its response into the same buffer, and then reports the response length with a done pulse. Writing command-ready at any time abandons the current transaction and gives a fresh, empty buffer.

Top module: `cmd_fifo_engine`

## Requirements
- R1: After reset, the status byte at offset 0x018 reads 0x00 and the burst count reads 0. Status bits: 7 status-valid, 6 command-ready, 5 go (always reads 0), 4 data-available, 3 expect, bits 2..0 read 0.
- R2: The burst count is 16 bits wide. Its low byte is at offset 0x019 and its high byte at 0x01A. The data port is at offset 0x024. Any other offset reads 0x00.
- R3: Expect reads 1 in the ready state and while fewer bytes than the command length have been accepted. It reads 0 on the first status read after the final byte. So the status is 0xC8 when ready, 0x88 during reception and 0x80 once the command is complete.
- R4: The command length is taken big-endian from header bytes 2 to 5, where byte 2 is the most significant. It is clamped to the range from 10, the header size, up to DEPTH.
- R5: Data-port writes are dropped outside the ready and reception states, and also once the command length has been reached. A dropped write changes neither the buffer, the flags nor the burst count.
- R6: A status write with bit 5 set, once the command is complete, raises `exec_start` for exactly one cycle and starts execution. The same write before the command is complete is ignored.
- R7: When `ex_done` arrives during execution, data-available rises if the response length is not 0. Data-port reads then return the response bytes in order. Data-available falls after the last byte is read, and any further read returns 0x00.
- R8: The burst count equals DEPTH minus the number of accepted command bytes in the ready and reception states. In the completion state it equals the number of unread response bytes, with the response length clamped to DEPTH. In every other state it is 0.
- R9: A status write with bit 6 set moves the block to the ready state from any state, with status 0xC8 and burst count DEPTH. An `ex_done` that arrives after such an abort is ignored.
- R10: During execution, `ex_rdata` returns the command byte at `ex_addr`, and an `ex_we` stores `ex_wdata` at `ex_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of the data port advances the response pointer) |
| reg_addr | input | ADDR_W | Byte offset inside the locality window |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the current address, combinational |
| exec_start | output | 1 | One-cycle pulse when execution begins |
| ex_addr | input | $clog2(DEPTH) | Executor buffer address |
| ex_rdata | output | 8 | Buffer byte at `ex_addr` |
| ex_we | input | 1 | Executor buffer write enable, honoured only while executing |
| ex_wdata | input | 8 | Executor write data |
| ex_done | input | 1 | Response ready, honoured only while executing |
| ex_rsp_len | input | 16 | Response length in bytes, sampled with `ex_done` |

## Verification
The assertions assume that the host issues at most one register access per cycle and that `reg_wr` and `reg_rd` never coincide. They also assume that the executor drives `ex_we` and `ex_done` only between an `exec_start` pulse and the status-valid done state. The bench keeps to these limits: it drives each access from a task that holds one strobe for one cycle, and it acts as the executor only after it has counted the start pulse. Its random stimulus picks command lengths inside the buffer and response lengths from 0 to DEPTH. Directed cases then push the length field below the header size and above the buffer size, and send an oversized response length.

// File: rtl/cmd_fifo_engine.sv
module cmd_fifo_engine #(
  parameter int DEPTH = 64,
  parameter int HDR_LEN = 10,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] STS_OFF = 'h018,
  parameter logic [ADDR_W-1:0] FIFO_OFF = 'h024
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_wr,
  input  logic                     reg_rd,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [7:0]               reg_wdata,
  output logic [7:0]               reg_rdata,
  output logic                     exec_start,
  input  logic [$clog2(DEPTH)-1:0] ex_addr,
  output logic [7:0]               ex_rdata,
  input  logic                     ex_we,
  input  logic [7:0]               ex_wdata,
  input  logic                     ex_done,
  input  logic [15:0]              ex_rsp_len
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [CW-1:0] HDR_C = CW'(HDR_LEN);

  typedef enum logic [2:0] {S_IDLE, S_READY, S_RECV, S_EXEC, S_DONE} state_t;

  state_t          st;
  logic [CW-1:0]   cnt, need, rlen, rptr;
  logic [23:0]     len_sh;
  logic [7:0]      mem [DEPTH];

  logic sts_sel, fifo_sel, sts_wr, abort, go, fifo_wr, fifo_rd;
  logic take, go_ok, pop, expect_f, davail;
  logic [7:0] status;
  logic [CW-1:0] burst_n;
  logic [15:0] burst;

  assign sts_sel  = reg_addr == STS_OFF;
  assign fifo_sel = reg_addr == FIFO_OFF;
  assign sts_wr   = reg_wr && sts_sel;
  assign abort    = sts_wr && reg_wdata[6];
  assign go       = sts_wr && reg_wdata[5] && !reg_wdata[6];
  assign fifo_wr  = reg_wr && fifo_sel;
  assign fifo_rd  = reg_rd && fifo_sel;

  assign expect_f = (st == S_READY) || (st == S_RECV && cnt < need);
  assign davail   = (st == S_DONE) && (rptr < rlen);
  assign take     = fifo_wr && expect_f;
  assign go_ok    = go && st == S_RECV && cnt == need;
  assign pop      = fifo_rd && davail;

  function automatic logic [CW-1:0] len_clamp(input logic [31:0] v);
    if (v < 32'(HDR_LEN)) return HDR_C;
    if (v > 32'(DEPTH)) return DEPTH_C;
    return v[CW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      need <= HDR_C;
      rlen <= '0;
      rptr <= '0;
      len_sh <= '0;
      exec_start <= 1'b0;
    end else begin
      exec_start <= 1'b0;
      if (abort) begin
        st <= S_READY;
        cnt <= '0;
        need <= HDR_C;
        rlen <= '0;
        rptr <= '0;
      end else begin
        case (st)
          S_READY, S_RECV: begin
            if (take) begin
              st <= S_RECV;
              cnt <= cnt + 1'b1;
              if (cnt >= CW'(2) && cnt <= CW'(5)) len_sh <= {len_sh[15:0], reg_wdata};
              if (cnt == CW'(5)) need <= len_clamp({len_sh, reg_wdata});
            end else if (go_ok) begin
              st <= S_EXEC;
              exec_start <= 1'b1;
            end
          end
          S_EXEC: if (ex_done) begin
            st <= S_DONE;
            rlen <= (ex_rsp_len > 16'(DEPTH)) ? DEPTH_C : ex_rsp_len[CW-1:0];
            rptr <= '0;
          end
          S_DONE: if (pop) rptr <= rptr + 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take) mem[cnt[AW-1:0]] <= reg_wdata;
    else if (st == S_EXEC && ex_we) mem[ex_addr] <= ex_wdata;
  end

  assign status  = {st != S_IDLE, st == S_READY, 1'b0, davail, expect_f, 3'b000};
  assign burst_n = (st == S_READY || st == S_RECV) ? DEPTH_C - cnt :
                   (st == S_DONE) ? rlen - rptr : '0;
  assign burst   = 16'(burst_n);
  assign ex_rdata = mem[ex_addr];

  always_comb begin
    reg_rdata = 8'h00;
    if (sts_sel) reg_rdata = status;
    else if (reg_addr == STS_OFF + 1'b1) reg_rdata = burst[7:0];
    else if (reg_addr == STS_OFF + 2'd2) reg_rdata = burst[15:8];
    else if (fifo_sel && davail) reg_rdata = mem[rptr[AW-1:0]];
  end

  assert_expect_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr && st == S_RECV && cnt + 1'b1 == need) |=> !status[3]);

  assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({status[3], status[4]}));

  assert_drop_outside_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr && (st == S_IDLE || st == S_EXEC || st == S_DONE)) |=> $stable(cnt));

  assert_early_go_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (go && st == S_RECV && cnt != need) |=> (st == S_RECV && !exec_start));

  assert_start_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exec_start |=> !exec_start);

  assert_davail_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (davail && !fifo_rd && !abort) |=> davail);

  assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (st == S_READY && burst == 16'(DEPTH)));
endmodule

// File: tb/cmd_fifo_engine_bench.sv
module cmd_fifo_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam int AW = 6;
  localparam logic [11:0] STS = 12'h018;
  localparam logic [11:0] FIFO = 12'h024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic exec_start;
  logic [AW-1:0] ex_addr = '0;
  logic [7:0] ex_rdata, ex_wdata = '0;
  logic ex_we = 1'b0, ex_done = 1'b0;
  logic [15:0] ex_rsp_len = '0;

  int checks = 0, errors = 0, starts = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (rst_n && exec_start) starts++;

  cmd_fifo_engine #(.DEPTH(DEPTH)) u_cmd_fifo_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .exec_start(exec_start),
    .ex_addr(ex_addr), .ex_rdata(ex_rdata), .ex_we(ex_we), .ex_wdata(ex_wdata),
    .ex_done(ex_done), .ex_rsp_len(ex_rsp_len));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic rd_burst(output logic [15:0] b);
    logic [7:0] lo, hi;
    rd(STS + 12'd1, lo);
    rd(STS + 12'd2, hi);
    b = {hi, lo};
  endtask

  function automatic int exp_need(input logic [31:0] len);
    if (len < 32'd10) return 10;
    if (len > 32'(DEPTH)) return DEPTH;
    return int'(len);
  endfunction

  task automatic run_cmd(input logic [31:0] len, input int extra, input int rl,
                         input bit early_go, input bit abort_exec);
    int need, rle, s0;
    logic [7:0] cmd [DEPTH+8];
    logic [7:0] rsp [DEPTH];
    logic [7:0] d;
    logic [15:0] b;
    need = exp_need(len);
    wr(STS, 8'h40);
    rd(STS, d); check("R9 ready status", d, 8'hC8);
    for (int i = 0; i < need + extra; i++) begin
      if (i >= 2 && i <= 5) cmd[i] = len[8*(5-i) +: 8];
      else cmd[i] = 8'($urandom);
    end
    for (int i = 0; i < need + extra; i++) begin
      if (i < need && (i == 0 || i == 5 || i == 6 || i == need - 1)) begin
        rd(STS, d); check("R3 expect high", d, (i == 0) ? 8'hC8 : 8'h88);
        rd_burst(b); check("R8 burst in reception", b, 16'(DEPTH - i));
      end
      if (early_go && i == need - 1) begin
        s0 = starts;
        wr(STS, 8'h20);
        @(negedge clk);
        check("R6 early go ignored", starts - s0, 0);
        rd(STS, d); check("R6 still receiving", d, 8'h88);
      end
      wr(FIFO, cmd[i]);
      if (i >= need) begin
        rd_burst(b); check("R5 extra byte dropped", b, 16'(DEPTH - need));
      end
    end
    rd(STS, d); check("R3 expect drops after final byte", d, 8'h80);
    rd_burst(b); check("R4 parsed length", b, 16'(DEPTH - need));
    s0 = starts;
    wr(STS, 8'h20);
    @(negedge clk);
    check("R6 go starts executor", starts - s0, 1);
    for (int i = 0; i < need; i++) begin
      ex_addr = AW'(i);
      #1 check("R10 executor sees command", ex_rdata, cmd[i]);
    end
    if (abort_exec) begin
      wr(STS, 8'h40);
      @(negedge clk); ex_done = 1'b1; ex_rsp_len = 16'd5;
      @(negedge clk); ex_done = 1'b0;
      rd(STS, d); check("R9 abort during execution", d, 8'hC8);
      rd_burst(b); check("R9 burst after abort", b, 16'(DEPTH));
      return;
    end
    rle = (rl > DEPTH) ? DEPTH : rl;
    for (int i = 0; i < rle; i++) begin
      rsp[i] = 8'($urandom);
      @(negedge clk); ex_we = 1'b1; ex_addr = AW'(i); ex_wdata = rsp[i];
    end
    @(negedge clk); ex_we = 1'b0; ex_done = 1'b1; ex_rsp_len = 16'(rl);
    @(negedge clk); ex_done = 1'b0;
    rd(STS, d); check("R7 data available", d, (rle > 0) ? 8'h90 : 8'h80);
    rd_burst(b); check("R8 burst in completion", b, 16'(rle));
    for (int i = 0; i < rle; i++) begin
      rd(FIFO, d); check("R7 response byte", d, rsp[i]);
    end
    rd(STS, d); check("R7 data available falls", d, 8'h80);
    rd_burst(b); check("R8 burst empty", b, 16'd0);
    rd(FIFO, d); check("R7 read past end", d, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [15:0] b;
    int s0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(STS, d); check("R1 reset status", d, 8'h00);
    rd_burst(b); check("R1 reset burst", b, 16'd0);
    wr(FIFO, 8'h55);
    s0 = starts;
    wr(STS, 8'h20);
    rd(STS, d); check("R5 idle write dropped", d, 8'h00);
    check("R6 go in idle ignored", starts - s0, 0);
    rd(12'h030, d); check("R2 unmapped offset", d, 8'h00);

    wr(STS, 8'h40);
    for (int i = 0; i < 4; i++) wr(FIFO, 8'(i));
    rd(STS, d); check("R3 mid reception", d, 8'h88);
    wr(STS, 8'h40);
    rd(STS, d); check("R9 abort in reception", d, 8'hC8);
    rd_burst(b); check("R9 burst after abort", b, 16'(DEPTH));

    run_cmd(32'd20, 0, 12, 1'b0, 1'b0);
    run_cmd(32'd3, 2, 4, 1'b1, 1'b0);
    run_cmd(32'h0001_0000, 3, DEPTH + 5, 1'b0, 1'b0);
    run_cmd(32'd16, 0, 0, 1'b0, 1'b0);
    run_cmd(32'd14, 0, 6, 1'b0, 1'b1);
    for (int n = 0; n < 20; n++)
      run_cmd(32'(10 + $urandom_range(DEPTH - 10)), int'($urandom_range(2)),
              int'($urandom_range(DEPTH)), n % 5 == 0, 1'b0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule